// File: doc/BRIEF.md
# Robbed-Bit Aware Companded Sample Expander

This block turns received 8-bit companded PCM bytes into signed linear samples for the receive path of a line interface. It decodes µ-law fully and, as a side option, A-law. It also supports robbed-bit signaling. In that scheme, equipment elsewhere in the system takes over the least significant bit of received bytes in some frames to carry signaling. The expander has to tell those frames apart from normal ones, and it does so by watching the frame sync pulse.

Frame sync is sampled at each falling edge of the bit clock `bclk`. The block counts the consecutive high samples and decides the frame type on the first low sample that follows. A pulse of exactly two samples marks a robbed-bit frame, unless the pulse before it was also two samples long. In a robbed-bit frame, with the enable set and µ-law selected, the received LSB of each accepted byte is dropped. The sample is then rebuilt at the midpoint between the decodes with LSB 0 and LSB 1. The output carries one fractional bit below the 14-bit linear scale so that this midpoint can be represented.

Bytes enter on a valid/ready stream and samples leave on one. The output stage is a single register. `pcm_ready` is high whenever that register is empty or is being drained in the same cycle, so a downstream stall holds the current sample and stops intake. `bclk` and `fsync` are assumed synchronous to `clk`, and each level is held for at least one `clk` period.

Top module: `rbs_mulaw_expander`

## Requirements
- R1: With µ-law selected and no substitution, a byte b is decoded as follows. Take u = ~b, e = u[6:4] and m = u[3:0], and form magnitude ((2m+33)<<e)-33. The value is negative when u[7] = 1. `out_sample` equals twice this value (the LSB is the fractional half bit).
- R2: With A-law selected (`law_mulaw` = 0), a byte b is decoded as follows. Take x = b ^ 0x55, e = x[6:4] and m = x[3:0]. The 13-bit magnitude is 2m+1 when e = 0, and (2m+33)<<(e-1) otherwise. The value is positive when x[7] = 1. `out_sample` equals four times this value.
- R3: A frame sync pulse seen high on exactly two consecutive bclk falling edges and low on the third makes the frame robbed-bit, provided the previous pulse was not exactly two samples long. Pulses of any other length make the frame normal.
- R4: A two-sample pulse that directly follows another two-sample pulse makes the frame normal, and the sample is decoded per R1.
- R5: In a robbed-bit frame with `rbe_en` = 1 and µ-law selected, every accepted byte yields dec(b with bit0 = 0) + dec(b with bit0 = 1). Here dec is the R1 value before doubling.
- R6: With `rbe_en` = 0, bytes in a robbed-bit frame are decoded per R1 using all 8 bits.
- R7: With A-law selected, no substitution occurs even with `rbe_en` = 1 in a robbed-bit frame, and the output follows R2.
- R8: After reset, `out_valid` is 0 and `pcm_ready` is 1. The previous-pulse record reads "not two", so the first two-sample pulse after reset gives a robbed-bit frame.
- R9: `fsync` is looked at only on bclk falling edges. A high level that starts and ends between two falling edges has no effect on classification.
- R10: A byte accepted on a clock edge appears on `out_sample` with `out_valid` = 1 after that edge. While `out_valid` = 1 and `out_ready` = 0, the sample is held and `pcm_ready` = 0. When `out_ready` = 1, a new byte can be accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled on bclk falling edges |
| rbe_en | input | 1 | Enables robbed-bit substitution |
| law_mulaw | input | 1 | 1 selects µ-law, 0 selects A-law |
| pcm_valid | input | 1 | Input byte valid |
| pcm_ready | output | 1 | Input byte accepted when high with pcm_valid |
| pcm_data | input | 8 | Received companded byte |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_sample | output | 15 | Signed linear sample, one fractional bit |

## Verification
A sample is due one clock after the edge that accepts its byte. The bench therefore drives on the falling clock edge and compares at the next falling edge, after exactly one register. The frame type changes on the clock edge that first sees bclk low with fsync low after a pulse. Every byte is sent only after that edge. The expected classification comes from a separate model of the pulse-length history, which is also cleared on reset. Under back-pressure, the held sample and the low ready are checked on each stalled cycle before release.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int CODE_W = 8;
  localparam int LIN_W  = 14;
  localparam int OUT_W  = LIN_W + 1;

  typedef logic signed [LIN_W-1:0] lin_t;
  typedef logic signed [OUT_W-1:0] smp_t;

  // mu-law byte to 14-bit linear value
  function automatic lin_t mu_decode(input logic [CODE_W-1:0] code);
    logic [7:0]  inv;
    logic [5:0]  seg;
    logic [13:0] mag;
    inv = ~code;
    seg = {1'b0, inv[3:0], 1'b1} + 6'd32;
    mag = (14'(seg) << inv[6:4]) - 14'd33;
    return inv[7] ? -lin_t'(mag) : lin_t'(mag);
  endfunction

  // A-law byte to the same 14-bit linear scale
  function automatic lin_t a_decode(input logic [CODE_W-1:0] code);
    logic [7:0]  x;
    logic [5:0]  seg;
    logic [12:0] mag;
    x   = code ^ 8'h55;
    seg = {1'b0, x[3:0], 1'b1} + ((x[6:4] == 3'd0) ? 6'd0 : 6'd32);
    mag = (x[6:4] == 3'd0) ? 13'(seg) : (13'(seg) << (x[6:4] - 3'd1));
    return x[7] ? lin_t'({mag, 1'b0}) : -lin_t'({mag, 1'b0});
  endfunction
endpackage

// File: rtl/rbs_frame_classifier.sv
module rbs_frame_classifier #(
  parameter int PULSE_CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic robbed_frame
);
  localparam logic [PULSE_CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PULSE_CNT_W-1:0] TWO     = PULSE_CNT_W'(2);

  logic                   bclk_q;
  logic [PULSE_CNT_W-1:0] hi_cnt;
  logic                   last_was_two;
  logic                   bclk_fall;

  assign bclk_fall = bclk_q & ~bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q       <= 1'b0;
      hi_cnt       <= '0;
      last_was_two <= 1'b0;
      robbed_frame <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (bclk_fall) begin
        if (fsync) begin
          if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + 1'b1;
        end else if (hi_cnt != '0) begin
          robbed_frame <= (hi_cnt == TWO) && !last_was_two;
          last_was_two <= (hi_cnt == TWO);
          hi_cnt       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rbs_sample_expander.sv
module rbs_sample_expander
  import rbs_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              law_mulaw,
  input  logic              half_lsb,
  output smp_t              sample
);
  lin_t bound [2];
  lin_t mu_full;
  lin_t a_full;

  genvar j;
  generate
    for (j = 0; j < 2; j++) begin : g_bound
      assign bound[j] = mu_decode({code[CODE_W-1:1], 1'(j)});
    end
  endgenerate

  assign mu_full = mu_decode(code);
  assign a_full  = a_decode(code);

  always_comb begin
    if (!law_mulaw)
      sample = {a_full, 1'b0};
    else if (half_lsb)
      sample = smp_t'(bound[0]) + smp_t'(bound[1]);
    else
      sample = {mu_full, 1'b0};
  end
endmodule

// File: rtl/rbs_mulaw_expander.sv
module rbs_mulaw_expander
  import rbs_pkg::*;
#(
  parameter int PULSE_CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rbe_en,
  input  logic              law_mulaw,
  input  logic              pcm_valid,
  output logic              pcm_ready,
  input  logic [CODE_W-1:0] pcm_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_sample
);
  logic robbed_frame;
  logic half_lsb;
  logic take;
  smp_t next_sample;

  rbs_frame_classifier #(.PULSE_CNT_W(PULSE_CNT_W)) u_class (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk         (bclk),
    .fsync        (fsync),
    .robbed_frame (robbed_frame)
  );

  assign half_lsb = robbed_frame & rbe_en & law_mulaw;

  rbs_sample_expander u_exp (
    .code      (pcm_data),
    .law_mulaw (law_mulaw),
    .half_lsb  (half_lsb),
    .sample    (next_sample)
  );

  assign pcm_ready = !out_valid || out_ready;
  assign take      = pcm_valid && pcm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_sample <= next_sample;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rbs_expander_chk.sv
module rbs_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        law_mulaw,
  input logic        pcm_valid,
  input logic        pcm_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [14:0] out_sample
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample)); // R10
  AST_NO_INTAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !pcm_ready); // R10
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid && pcm_ready |=> out_valid); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcm_valid && pcm_ready) && !(out_valid && !out_ready) |=> !out_valid); // R10
  AST_ALAW_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid && pcm_ready && !law_mulaw |=> out_sample[1:0] == 2'b00); // R7
endmodule

bind rbs_mulaw_expander rbs_expander_chk u_chk (.*);

// File: tb/rbs_mulaw_expander_test.sv
module rbs_mulaw_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fsync = 1'b0;
  logic        rbe_en = 1'b0;
  logic        law_mulaw = 1'b1;
  logic        pcm_valid = 1'b0;
  logic        pcm_ready;
  logic [7:0]  pcm_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [14:0] out_sample;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  prev_two = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  rbs_mulaw_expander uut (.*);

  // {pulse length[3:0], rbe, mu-law, byte}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b1, 8'h5A}, {4'd2, 1'b1, 1'b1, 8'h33},
    {4'd3, 1'b1, 1'b1, 8'hC4}, {4'd2, 1'b1, 1'b1, 8'h81},
    {4'd1, 1'b1, 1'b1, 8'h00}, {4'd2, 1'b0, 1'b1, 8'h97},
    {4'd4, 1'b1, 1'b1, 8'hFF}, {4'd2, 1'b1, 1'b0, 8'hD5},
    {4'd1, 1'b1, 1'b0, 8'h2A}, {4'd2, 1'b1, 1'b1, 8'h7E},
    {4'd2, 1'b1, 1'b1, 8'h01}, {4'd5, 1'b0, 1'b0, 8'h55},
    {4'd2, 1'b1, 1'b1, 8'hEC}
  };

  function automatic int mu_ref(input bit [7:0] b);
    bit [7:0] u = ~b;
    int e = int'(u[6:4]);
    int m = int'(u[3:0]);
    int mag = ((((m + 16) * 2) + 1) << e) - 33;
    return u[7] ? -mag : mag;
  endfunction

  function automatic int a_ref(input bit [7:0] b);
    bit [7:0] x = b ^ 8'h55;
    int e = int'(x[6:4]);
    int m = int'(x[3:0]);
    int mag = (e == 0) ? (2 * m + 1) : ((2 * m + 33) << (e - 1));
    return x[7] ? mag : -mag;
  endfunction

  function automatic int expect_of(input bit [7:0] b, input bit mu, input bit rbe, input bit robbed);
    if (!mu) return 4 * a_ref(b);
    if (robbed && rbe) return mu_ref(b & 8'hFE) + mu_ref(b | 8'h01);
    return 2 * mu_ref(b);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit fs);
    @(negedge clk); fsync = fs; bclk = 1'b1;
    @(negedge clk);
    @(negedge clk); bclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick_glitch;
    @(negedge clk); fsync = 1'b0; bclk = 1'b1;
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0; bclk = 1'b0;
    @(negedge clk);
  endtask

  // returns model classification
  task automatic frame(input int len, output bit robbed);
    for (int i = 0; i < len; i++) tick(1'b1);
    tick(1'b0);
    robbed = (len == 2) && !prev_two;
    prev_two = (len == 2);
  endtask

  task automatic send_check(input bit [7:0] b, input int exp, input string tag);
    logic signed [14:0] e15;
    e15 = 15'(exp);
    @(negedge clk); pcm_data = b; pcm_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk); pcm_valid = 1'b0;
    check(out_valid === 1'b1 && $signed(out_sample) === e15, tag,
          int'($signed(out_sample)), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit rob;
    string tag;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R8 out_valid reset", int'(out_valid), 0);
    check(pcm_ready === 1'b1, "R8 pcm_ready reset", int'(pcm_ready), 1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      bit pt;
      pt = prev_two;
      rbe_en = VEC[k][9];
      law_mulaw = VEC[k][8];
      frame(int'(VEC[k][13:10]), rob);
      if (!VEC[k][8]) tag = rob ? "R7 alaw in robbed frame" : "R2 alaw decode";
      else if (rob && VEC[k][9]) tag = (k == 0) ? "R8 R5 R3 first robbed" : "R5 R3 half lsb";
      else if (rob) tag = "R6 rbe off";
      else if (pt && VEC[k][13:10] == 4'd2) tag = "R4 repeated two";
      else tag = "R1 R3 normal decode";
      send_check(VEC[k][7:0], expect_of(VEC[k][7:0], VEC[k][8], VEC[k][9], rob), tag);
    end

    // R5: every valid byte of a robbed frame is substituted
    rbe_en = 1'b1; law_mulaw = 1'b1;
    frame(3, rob);
    frame(2, rob);
    send_check(8'h10, expect_of(8'h10, 1, 1, rob), "R5 slot a");
    send_check(8'hA3, expect_of(8'hA3, 1, 1, rob), "R5 slot b");

    // R9: fsync high only between falling edges
    frame(3, rob);
    tick(1'b1); tick(1'b1); tick_glitch();
    rob = !prev_two; prev_two = 1'b1;
    send_check(8'h6B, expect_of(8'h6B, 1, 1, rob), "R9 glitch ignored");

    // R8: reset clears previous-pulse record
    frame(2, rob);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; prev_two = 1'b0;
    frame(2, rob);
    send_check(8'h4D, expect_of(8'h4D, 1, 1, rob), "R8 after reset");

    // R10: back-pressure
    rbe_en = 1'b0;
    @(negedge clk); out_ready = 1'b0; pcm_data = 8'h22; pcm_valid = 1'b1;
    @(negedge clk); pcm_data = 8'hB9;
    check(pcm_ready === 1'b0, "R10 ready low", int'(pcm_ready), 0);
    @(negedge clk);
    check(out_valid === 1'b1 && $signed(out_sample) === 15'(2 * mu_ref(8'h22)),
          "R10 held", int'($signed(out_sample)), 2 * mu_ref(8'h22));
    out_ready = 1'b1;
    @(negedge clk); pcm_valid = 1'b0;
    check(out_valid === 1'b1 && $signed(out_sample) === 15'(2 * mu_ref(8'hB9)),
          "R10 release", int'($signed(out_sample)), 2 * mu_ref(8'hB9));
    @(negedge clk);
    check(out_valid === 1'b0, "R10 drained", int'(out_valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule